// File: doc/BRIEF.md
# Banked Register File with Direct and Indexed Addressing

This unit is the working-register store of a small 8-bit controller. It holds 48 bytes arranged as six banks of eight. Bank 0 contains four accumulators, three base registers and a status register. Banks 1 to 5 are general data RAM. The instruction decoder hands the unit one register reference per cycle and expects the selected byte back in the same cycle. A write commits at the next rising clock edge.

A reference takes one of two forms. A direct reference carries a register number from 0 to 31. An indexed reference names one of three families (low, middle, high) and a slot from 0 to 7. Each family takes its bank number from its own base register, and the physical address is that bank number times eight plus the slot. Bit 0 of the status register picks which of the two forms may reach registers 8 to 31. A reference that is not allowed returns zero, changes nothing, and raises an error strobe. An indexed reference whose bank lies beyond the internal banks is sent out on a simple external port instead.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every location reads 0x00. This includes the base registers and the status register, so the unit starts in direct mode.
- R2: Direct references to registers 0 to 7 always reach the register, whatever the value of status bit 0.
- R3: While status bit 0 is 0, direct references to registers 8 to 31 read and write physical locations 8 to 31. Every indexed reference is refused.
- R4: While status bit 0 is 1, indexed references are served and direct references to registers 8 to 31 are refused.
- R5: The family code on `acc_family` selects the base register: 0 uses register 4, 1 uses register 5 and 2 uses register 6. The physical address is base×8 + `acc_idx`. Family code 3 is refused.
- R6: A refused reference drives `acc_rdata` to 0x00 and leaves all storage unchanged. It drives `access_error` high only in the cycle of that reference.
- R7: A value written to a base register is used for address generation by an indexed reference in the very next clock cycle.
- R8: An indexed reference that resolves to bank 0 (base value 0) is refused, so registers 0 to 7 are only reachable directly.
- R9: An indexed reference whose base value is 6 or more is forwarded to the external port. In that cycle `ext_valid` is 1, `ext_addr` is base×8 + slot, `ext_we` and `ext_wdata` follow the request, and `acc_rdata` returns `ext_rdata`. Internal storage is unchanged. Bases 1 to 5 never assert `ext_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A register reference is present this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_indexed | input | 1 | 1 = indexed reference, 0 = direct reference |
| acc_reg | input | 5 | Register number for a direct reference |
| acc_family | input | 2 | Family for an indexed reference (0 low, 1 middle, 2 high) |
| acc_idx | input | 3 | Slot within the bank for an indexed reference |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, same cycle |
| access_error | output | 1 | Reference refused this cycle |
| ext_valid | output | 1 | Reference forwarded to the external port |
| ext_we | output | 1 | Forwarded reference is a write |
| ext_addr | output | 11 | Physical address of the forwarded reference |
| ext_wdata | output | 8 | Write data for the forwarded reference |
| ext_rdata | input | 8 | Read data returned by the external side |

## Verification
The direct number space is walked with status bit 0 at each value. This shows that registers 0 to 7 stay open while the upper registers switch between open and refused. Indexed references are tried with each family against different base values, so a mixed-up family or a wrong bank multiplier lands on a byte of known, distinct content. Base values of 0, 1 to 5, 6 and 255 separate the refused, internal and external outcomes. A write to a base register is followed in the next cycle by an indexed read, which exposes any extra register stage in the address path.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

  localparam int RF_DATA_W  = 8;
  localparam int RF_SLOT_W  = 3;
  localparam int RF_PADDR_W = RF_DATA_W + RF_SLOT_W;

  // Fixed slots within bank 0
  localparam int SLOT_BASE_LO  = 4;
  localparam int SLOT_BASE_MID = 5;
  localparam int SLOT_BASE_HI  = 6;
  localparam int SLOT_STATUS   = 7;

  typedef enum logic [1:0] {
    FAM_LO  = 2'd0,
    FAM_MID = 2'd1,
    FAM_HI  = 2'd2,
    FAM_BAD = 2'd3
  } family_e;

  // Physical address of an indexed name: bank*8 + slot
  function automatic logic [RF_PADDR_W-1:0] idx_phys_addr(
      input logic [RF_DATA_W-1:0] bank,
      input logic [RF_SLOT_W-1:0] slot);
    return {bank, slot};
  endfunction

endpackage

// File: rtl/rf_addr_gen.sv
module rf_addr_gen
  import banked_regfile_pkg::*;
#(
  parameter int NUM_BANKS   = 6,
  parameter int DIRECT_REGS = 32,
  localparam int REG_W      = $clog2(DIRECT_REGS),
  localparam int BANK_SLOTS = 1 << RF_SLOT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  valid,
  input  logic                  indexed,
  input  logic [REG_W-1:0]      reg_num,
  input  logic [1:0]            family,
  input  logic [RF_SLOT_W-1:0]  slot,
  input  logic [RF_DATA_W-1:0]  base_lo,
  input  logic [RF_DATA_W-1:0]  base_mid,
  input  logic [RF_DATA_W-1:0]  base_hi,
  input  logic                  index_mode,
  output logic [RF_PADDR_W-1:0] phys_addr,
  output logic                  hit_int,
  output logic                  hit_ext,
  output logic                  blocked
);

  logic [RF_DATA_W-1:0] sel_base;
  logic                 fam_bad;
  logic                 low_direct;

  always_comb begin
    fam_bad = 1'b0;
    case (family_e'(family))
      FAM_LO:  sel_base = base_lo;
      FAM_MID: sel_base = base_mid;
      FAM_HI:  sel_base = base_hi;
      default: begin
        sel_base = '0;
        fam_bad  = 1'b1;
      end
    endcase
  end

  assign low_direct = (reg_num < REG_W'(BANK_SLOTS));

  always_comb begin
    phys_addr = '0;
    hit_int   = 1'b0;
    hit_ext   = 1'b0;
    blocked   = 1'b0;
    if (valid) begin
      if (!indexed) begin
        phys_addr = RF_PADDR_W'(reg_num);
        if (low_direct || !index_mode) hit_int = 1'b1;
        else                           blocked = 1'b1;
      end else begin
        phys_addr = idx_phys_addr(sel_base, slot);
        if (!index_mode || fam_bad || sel_base == '0)  blocked = 1'b1;
        else if (sel_base >= RF_DATA_W'(NUM_BANKS))    hit_ext = 1'b1;
        else                                           hit_int = 1'b1;
      end
    end
  end

  // R2: low direct registers are always reachable at their own number
  p_low_direct_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !indexed && low_direct) |-> (hit_int && phys_addr == RF_PADDR_W'(reg_num)));

  // R3: indexed references are refused in direct mode
  p_indexed_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && indexed && !index_mode) |-> blocked);

  // R4: upper direct registers are refused in indexed mode
  p_upper_direct_shut_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !indexed && !low_direct && index_mode) |-> (blocked && !hit_int));

  // R6: each reference has exactly one outcome
  p_single_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($countones({hit_int, hit_ext, blocked}) == 1));

endmodule

// File: rtl/rf_storage.sv
module rf_storage
  import banked_regfile_pkg::*;
#(
  parameter int NUM_BANKS = 6,
  localparam int WORDS    = NUM_BANKS << RF_SLOT_W,
  localparam int AW       = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  input  logic [RF_DATA_W-1:0] wdata,
  output logic [RF_DATA_W-1:0] rdata,
  output logic [RF_DATA_W-1:0] base_lo,
  output logic [RF_DATA_W-1:0] base_mid,
  output logic [RF_DATA_W-1:0] base_hi,
  output logic                 index_mode
);

  logic [RF_DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata      = mem[addr];
  assign base_lo    = mem[SLOT_BASE_LO];
  assign base_mid   = mem[SLOT_BASE_MID];
  assign base_hi    = mem[SLOT_BASE_HI];
  assign index_mode = mem[SLOT_STATUS][0];

  // R7: a written byte is readable at its address on the following cycle
  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_regfile_pkg::*;
#(
  parameter int NUM_BANKS   = 6,
  parameter int DIRECT_REGS = 32,
  localparam int REG_W      = $clog2(DIRECT_REGS),
  localparam int WORDS      = NUM_BANKS << RF_SLOT_W,
  localparam int IAW        = $clog2(WORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic                  acc_we,
  input  logic                  acc_indexed,
  input  logic [REG_W-1:0]      acc_reg,
  input  logic [1:0]            acc_family,
  input  logic [RF_SLOT_W-1:0]  acc_idx,
  input  logic [RF_DATA_W-1:0]  acc_wdata,
  output logic [RF_DATA_W-1:0]  acc_rdata,
  output logic                  access_error,
  output logic                  ext_valid,
  output logic                  ext_we,
  output logic [RF_PADDR_W-1:0] ext_addr,
  output logic [RF_DATA_W-1:0]  ext_wdata,
  input  logic [RF_DATA_W-1:0]  ext_rdata
);

  logic [RF_PADDR_W-1:0] phys_addr;
  logic                  hit_int, hit_ext, blocked;
  logic [RF_DATA_W-1:0]  base_lo, base_mid, base_hi, int_rdata;
  logic                  index_mode;

  rf_addr_gen #(.NUM_BANKS(NUM_BANKS), .DIRECT_REGS(DIRECT_REGS)) u_agen (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (acc_valid),
    .indexed    (acc_indexed),
    .reg_num    (acc_reg),
    .family     (acc_family),
    .slot       (acc_idx),
    .base_lo    (base_lo),
    .base_mid   (base_mid),
    .base_hi    (base_hi),
    .index_mode (index_mode),
    .phys_addr  (phys_addr),
    .hit_int    (hit_int),
    .hit_ext    (hit_ext),
    .blocked    (blocked)
  );

  rf_storage #(.NUM_BANKS(NUM_BANKS)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (hit_int && acc_we),
    .addr       (phys_addr[IAW-1:0]),
    .wdata      (acc_wdata),
    .rdata      (int_rdata),
    .base_lo    (base_lo),
    .base_mid   (base_mid),
    .base_hi    (base_hi),
    .index_mode (index_mode)
  );

  always_comb begin
    if (hit_int)      acc_rdata = int_rdata;
    else if (hit_ext) acc_rdata = ext_rdata;
    else              acc_rdata = '0;
  end

  assign access_error = blocked;
  assign ext_valid    = hit_ext;
  assign ext_we       = hit_ext && acc_we;
  assign ext_addr     = hit_ext ? phys_addr : '0;
  assign ext_wdata    = hit_ext ? acc_wdata : '0;

  // R6: a refused reference reads as zero
  p_refused_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    access_error |-> (acc_rdata == '0 && !ext_valid));

  // R6: a refused write leaves base and status state alone
  p_refused_write_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (access_error && acc_we) |=> $stable({base_lo, base_mid, base_hi, index_mode}));

  // R9: forwarded addresses always lie beyond the internal banks
  p_ext_beyond_banks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> (ext_addr[RF_PADDR_W-1:RF_SLOT_W] >= RF_DATA_W'(NUM_BANKS)));

  // R8: bank 0 is never reached by an indexed reference
  p_no_indexed_bank0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_indexed && !access_error) |-> (phys_addr[RF_PADDR_W-1:RF_SLOT_W] != '0));

endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;

  typedef struct packed {
    logic        we;
    logic        ind;
    logic [4:0]  rn;
    logic [1:0]  fam;
    logic [2:0]  idx;
    logic [7:0]  wd;
    logic [7:0]  exp_rd;
    logic        exp_err;
    logic        exp_ext;
    logic [10:0] exp_addr;
  } vec_t;

  localparam logic [7:0] EXT_DATA = 8'hC7;
  localparam int NVEC = 33;

  // fields: we ind reg fam idx wdata exp_rdata exp_err exp_ext exp_addr
  localparam vec_t VEC [NVEC] = '{
    '{1'b1,1'b0,5'd8, 2'd0,3'd0,8'h11,8'h00,1'b0,1'b0,11'd0},   // R3 write R8
    '{1'b0,1'b0,5'd8, 2'd0,3'd0,8'h00,8'h11,1'b0,1'b0,11'd0},   // R3
    '{1'b1,1'b0,5'd0, 2'd0,3'd0,8'hA5,8'h00,1'b0,1'b0,11'd0},   // R2
    '{1'b0,1'b0,5'd0, 2'd0,3'd0,8'h00,8'hA5,1'b0,1'b0,11'd0},   // R2
    '{1'b1,1'b0,5'd31,2'd0,3'd0,8'h3C,8'h00,1'b0,1'b0,11'd0},   // R3
    '{1'b0,1'b0,5'd31,2'd0,3'd0,8'h00,8'h3C,1'b0,1'b0,11'd0},   // R3
    '{1'b0,1'b1,5'd0, 2'd0,3'd0,8'h00,8'h00,1'b1,1'b0,11'd0},   // R3 indexed refused
    '{1'b1,1'b1,5'd0, 2'd0,3'd0,8'hFF,8'h00,1'b1,1'b0,11'd0},   // R6 refused write
    '{1'b0,1'b0,5'd8, 2'd0,3'd0,8'h00,8'h11,1'b0,1'b0,11'd0},   // R6 R8 unchanged
    '{1'b1,1'b0,5'd4, 2'd0,3'd0,8'h01,8'h00,1'b0,1'b0,11'd0},   // low base = 1
    '{1'b1,1'b0,5'd5, 2'd0,3'd0,8'h03,8'h00,1'b0,1'b0,11'd0},   // mid base = 3
    '{1'b1,1'b0,5'd6, 2'd0,3'd0,8'h05,8'h00,1'b0,1'b0,11'd0},   // high base = 5
    '{1'b1,1'b0,5'd7, 2'd0,3'd0,8'h01,8'h00,1'b0,1'b0,11'd0},   // indexed mode on
    '{1'b0,1'b0,5'd8, 2'd0,3'd0,8'h00,8'h00,1'b1,1'b0,11'd0},   // R4 refused
    '{1'b1,1'b0,5'd9, 2'd0,3'd0,8'h77,8'h00,1'b1,1'b0,11'd0},   // R4 refused write
    '{1'b0,1'b1,5'd0, 2'd0,3'd0,8'h00,8'h11,1'b0,1'b0,11'd0},   // R5 low slot0 -> 8
    '{1'b0,1'b1,5'd0, 2'd0,3'd1,8'h00,8'h00,1'b0,1'b0,11'd0},   // R6 R9 kept 0
    '{1'b0,1'b1,5'd0, 2'd1,3'd7,8'h00,8'h3C,1'b0,1'b0,11'd0},   // R5 mid slot7 -> 31
    '{1'b1,1'b1,5'd0, 2'd2,3'd7,8'h5A,8'h00,1'b0,1'b0,11'd0},   // R5 high slot7 -> 47
    '{1'b0,1'b1,5'd0, 2'd2,3'd7,8'h00,8'h5A,1'b0,1'b0,11'd0},   // R5
    '{1'b0,1'b0,5'd0, 2'd0,3'd0,8'h00,8'hA5,1'b0,1'b0,11'd0},   // R2 in indexed mode
    '{1'b0,1'b1,5'd0, 2'd3,3'd0,8'h00,8'h00,1'b1,1'b0,11'd0},   // R5 family 3
    '{1'b1,1'b0,5'd4, 2'd0,3'd0,8'h00,8'h00,1'b0,1'b0,11'd0},   // low base = 0
    '{1'b0,1'b1,5'd0, 2'd0,3'd2,8'h00,8'h00,1'b1,1'b0,11'd0},   // R8 bank 0
    '{1'b1,1'b0,5'd4, 2'd0,3'd0,8'h06,8'h00,1'b0,1'b0,11'd0},   // low base = 6
    '{1'b0,1'b1,5'd0, 2'd0,3'd3,8'h00,EXT_DATA,1'b0,1'b1,11'h033}, // R9
    '{1'b1,1'b0,5'd4, 2'd0,3'd0,8'hFF,8'h00,1'b0,1'b0,11'd0},   // low base = 255
    '{1'b1,1'b1,5'd0, 2'd0,3'd7,8'h99,8'h00,1'b0,1'b1,11'h7FF}, // R9 write
    '{1'b0,1'b0,5'd4, 2'd0,3'd0,8'h00,8'hFF,1'b0,1'b0,11'd0},   // R2
    '{1'b1,1'b0,5'd7, 2'd0,3'd0,8'h00,8'h00,1'b0,1'b0,11'd0},   // direct mode back
    '{1'b0,1'b0,5'd8, 2'd0,3'd0,8'h00,8'h11,1'b0,1'b0,11'd0},   // R3
    '{1'b0,1'b0,5'd9, 2'd0,3'd0,8'h00,8'h00,1'b0,1'b0,11'd0},   // R4 refused write left 0
    '{1'b0,1'b0,5'd31,2'd0,3'd0,8'h00,8'h3C,1'b0,1'b0,11'd0}    // R9 ext write left RAM
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_we, acc_indexed;
  logic [4:0]  acc_reg;
  logic [1:0]  acc_family;
  logic [2:0]  acc_idx;
  logic [7:0]  acc_wdata, acc_rdata, ext_wdata, ext_rdata;
  logic        access_error, ext_valid, ext_we;
  logic [10:0] ext_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
    .acc_indexed(acc_indexed), .acc_reg(acc_reg), .acc_family(acc_family),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .access_error(access_error), .ext_valid(ext_valid), .ext_we(ext_we),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one reference at the falling edge; sample halfway to the rising edge
  task automatic drive(input logic we, input logic ind, input logic [4:0] rn,
                       input logic [1:0] fam, input logic [2:0] idx, input logic [7:0] wd);
    @(negedge clk);
    acc_valid = 1'b1; acc_we = we; acc_indexed = ind;
    acc_reg = rn; acc_family = fam; acc_idx = idx; acc_wdata = wd;
    #5;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0; acc_we = 1'b0; acc_indexed = 1'b0;
    #5;
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.exp_err) return "R6";
    if (v.exp_ext) return "R9";
    if (v.ind)     return "R5";
    return "R3";
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_we = 1'b0; acc_indexed = 1'b0;
    acc_reg = '0; acc_family = '0; acc_idx = '0; acc_wdata = '0;
    ext_rdata = EXT_DATA;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: every direct number reads zero after reset
    for (int r = 0; r < 32; r++) begin
      drive(1'b0, 1'b0, 5'(r), 2'd0, 3'd0, 8'h00);
      chk("R1 rdata", 32'(acc_rdata), 32'h0);
    end
    chk("R1 no error", 32'(access_error), 32'h0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].we, VEC[i].ind, VEC[i].rn, VEC[i].fam, VEC[i].idx, VEC[i].wd);
      chk(tag_of(VEC[i]), 32'(access_error), 32'(VEC[i].exp_err));
      chk("R9 ext_valid", 32'(ext_valid), 32'(VEC[i].exp_ext));
      if (!VEC[i].we) chk(tag_of(VEC[i]), 32'(acc_rdata), 32'(VEC[i].exp_rd));
      if (VEC[i].exp_ext) begin
        chk("R9 ext_addr", 32'(ext_addr), 32'(VEC[i].exp_addr));
        chk("R9 ext_we", 32'(ext_we), 32'(VEC[i].we));
        if (VEC[i].we) chk("R9 ext_wdata", 32'(ext_wdata), 32'(VEC[i].wd));
      end
    end

    // R6: error strobe only in the refused cycle
    drive(1'b0, 1'b1, 5'd0, 2'd0, 3'd0, 8'h00);
    chk("R6 strobe on", 32'(access_error), 32'h1);
    idle();
    chk("R6 strobe off", 32'(access_error), 32'h0);
    chk("R6 idle rdata", 32'(acc_rdata), 32'h0);

    // R7: base write used by the very next indexed reference
    drive(1'b1, 1'b0, 5'd7, 2'd0, 3'd0, 8'h01);
    drive(1'b1, 1'b0, 5'd4, 2'd0, 3'd0, 8'h01);
    drive(1'b1, 1'b1, 5'd0, 2'd0, 3'd0, 8'hE1);   // location 8
    drive(1'b1, 1'b0, 5'd4, 2'd0, 3'd0, 8'h02);
    drive(1'b0, 1'b1, 5'd0, 2'd0, 3'd0, 8'h00);   // location 16
    chk("R7 new base", 32'(acc_rdata), 32'h0);
    drive(1'b1, 1'b1, 5'd0, 2'd0, 3'd0, 8'h6B);   // location 16
    drive(1'b1, 1'b0, 5'd4, 2'd0, 3'd0, 8'h01);
    drive(1'b0, 1'b1, 5'd0, 2'd0, 3'd0, 8'h00);   // location 8
    chk("R7 back to bank 1", 32'(acc_rdata), 32'hE1);
    drive(1'b0, 1'b0, 5'd16, 2'd0, 3'd0, 8'h00);
    chk("R4 direct 16 refused", 32'(access_error), 32'h1);

    // R1: reset again clears storage and mode
    @(negedge clk) rst_n = 1'b0; acc_valid = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    drive(1'b0, 1'b0, 5'd16, 2'd0, 3'd0, 8'h00);
    chk("R1 mode cleared", 32'(access_error), 32'h0);
    chk("R1 data cleared", 32'(acc_rdata), 32'h0);
    drive(1'b0, 1'b0, 5'd7, 2'd0, 3'd0, 8'h00);
    chk("R1 status cleared", 32'(acc_rdata), 32'h0);
    idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule